// File: doc/BRIEF.md
# Channel Length Counter with Staged Updates

This block holds the length count of one sound channel. Software writes a 5-bit load index, which selects a count from a fixed 32-entry table, and a halt bit. The channel enable and a half-frame clock strobe also drive the block. The count runs down once per half-frame clock. A nonzero count opens the channel's output gate.

Halt changes and reloads do not act at the moment they are written. Each is captured into a staging record, and the staging record is merged into the state only after that cycle's half-frame clock has been applied. The record for a reload also holds a snapshot of the count as it was before the clock. If the clock changed the count in the same cycle, the reload is discarded. Otherwise it settles within the cycle of the write. A halt change written on a clock cycle governs only the clocks that come after it.

One rising edge of `clk` stands for one CPU cycle. Every strobe is sampled at that edge.

Top module: `lc_length_top`

## Requirements
- R1: While `rst` is high, and after it is released, `count_o` is 0, `halt_o` is 0 and `active_o` is 0.
- R2: A `half_clk_i` cycle with the channel enabled lowers `count_o` by 1 at that edge, provided the count is nonzero and the halt state was clear before the edge. At count 0 the count stays at 0.
- R3: A `half_clk_i` cycle leaves `count_o` unchanged when the halt state before the edge was set.
- R4: A write through `halt_wr_i` loads `halt_i` into `halt_o` at that edge. The half-frame clock of the same cycle still uses the halt value from before the write.
- R5: A reload (`load_wr_i` with the channel enabled) sets `count_o` to table[`load_idx_i`] at that edge, unless R6 applies. Odd index n gives n-1, except index 1, which gives 254. Even indices 0,2,...,14 give 10,20,40,80,160,60,14,26. Even indices 16,...,30 give 12,24,48,96,192,72,16,32.
- R6: A reload is discarded when the half-frame clock of the same cycle decremented the count. In that case the count only takes the decrement.
- R7: With `en_i` low, `count_o` becomes 0 at the edge and reloads are ignored. Raising `en_i` alone does not change the count.
- R8: `active_o` is high exactly when `count_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per CPU cycle |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable |
| load_wr_i | input | 1 | Reload write strobe |
| load_idx_i | input | 5 | Length table index carried by the reload write |
| halt_wr_i | input | 1 | Halt write strobe |
| halt_i | input | 1 | Halt value carried by the halt write |
| half_clk_i | input | 1 | Half-frame clock strobe |
| count_o | output | 8 | Current length count |
| halt_o | output | 1 | Committed halt state |
| active_o | output | 1 | Channel gate, high while the count is nonzero |

## Verification
The hardest situations to reach are the coincidences: a reload or a halt write that lands on the very edge of a half-frame clock. For these, the outcome depends on whether the count was nonzero and on the halt value that was in force before the write. The stimulus first builds a known count and halt state with single-purpose cycles. It then fires the write and the clock in the same cycle, once with a count that decrements (so the reload is dropped), once with halt set, and once at count 0 (in both of these the reload survives). It also toggles halt in the same cycle as a clock, in both directions.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int CNT_W = 8;
    localparam int IDX_W = 5;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;

    // Staged writes for one cycle, merged after the half-frame clock
    typedef struct packed {
        logic halt_vld;
        logic halt_val;
        logic rld_vld;
        cnt_t rld_val;
        cnt_t snap;
    } stage_t;

    // Length table computed from the index bits
    function automatic cnt_t lc_len_lookup(input idx_t idx);
        cnt_t base;
        cnt_t res;
        base = idx[IDX_W-1] ? cnt_t'(12) : cnt_t'(10);
        if (idx[0]) begin
            res = (idx == idx_t'(1)) ? cnt_t'(254) : (cnt_t'(idx) - cnt_t'(1));
        end else begin
            case (idx[3:1])
                3'd0:    res = base;
                3'd1:    res = cnt_t'(base << 1);
                3'd2:    res = cnt_t'(base << 2);
                3'd3:    res = cnt_t'(base << 3);
                3'd4:    res = cnt_t'(base << 4);
                3'd5:    res = cnt_t'((base << 2) + (base << 1));
                3'd6:    res = idx[IDX_W-1] ? cnt_t'(16) : cnt_t'(14);
                default: res = idx[IDX_W-1] ? cnt_t'(32) : cnt_t'(26);
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/lc_stage.sv
module lc_stage
    import lc_pkg::*;
(
    input  logic   en_i,
    input  logic   load_wr_i,
    input  idx_t   load_idx_i,
    input  logic   halt_wr_i,
    input  logic   halt_i,
    input  cnt_t   count_q,
    output stage_t stg_o
);
    always_comb begin
        stg_o.halt_vld = halt_wr_i;
        stg_o.halt_val = halt_i;
        stg_o.rld_vld  = load_wr_i & en_i;
        stg_o.rld_val  = lc_len_lookup(load_idx_i);
        stg_o.snap     = count_q;
    end
endmodule

// File: rtl/lc_clock.sv
module lc_clock
    import lc_pkg::*;
(
    input  logic half_clk_i,
    input  logic halt_q,
    input  cnt_t count_q,
    output cnt_t count_clk_o
);
    always_comb begin
        if (half_clk_i && !halt_q && (count_q != '0))
            count_clk_o = count_q - cnt_t'(1);
        else
            count_clk_o = count_q;
    end
endmodule

// File: rtl/lc_commit.sv
module lc_commit
    import lc_pkg::*;
(
    input  logic   en_i,
    input  stage_t stg_i,
    input  cnt_t   count_clk_i,
    input  logic   halt_q,
    output cnt_t   count_d,
    output logic   halt_d
);
    always_comb begin
        if (!en_i)
            count_d = '0;
        else if (stg_i.rld_vld && (count_clk_i == stg_i.snap))
            count_d = stg_i.rld_val;
        else
            count_d = count_clk_i;
        halt_d = stg_i.halt_vld ? stg_i.halt_val : halt_q;
    end
endmodule

// File: rtl/lc_length_top.sv
module lc_length_top
    import lc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             load_wr_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic             halt_wr_i,
    input  logic             halt_i,
    input  logic             half_clk_i,
    output logic [CNT_W-1:0] count_o,
    output logic             halt_o,
    output logic             active_o
);
    cnt_t   count_q, count_clk, count_d;
    logic   halt_q, halt_d;
    stage_t stg;

    lc_stage u_stage (
        .en_i      (en_i),
        .load_wr_i (load_wr_i),
        .load_idx_i(load_idx_i),
        .halt_wr_i (halt_wr_i),
        .halt_i    (halt_i),
        .count_q   (count_q),
        .stg_o     (stg)
    );

    lc_clock u_clock (
        .half_clk_i (half_clk_i),
        .halt_q     (halt_q),
        .count_q    (count_q),
        .count_clk_o(count_clk)
    );

    lc_commit u_commit (
        .en_i       (en_i),
        .stg_i      (stg),
        .count_clk_i(count_clk),
        .halt_q     (halt_q),
        .count_d    (count_d),
        .halt_d     (halt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            halt_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            halt_q  <= halt_d;
        end
    end

    assign count_o  = count_q;
    assign halt_o   = halt_q;
    assign active_o = (count_q != '0);
endmodule

// File: rtl/lc_checker.sv
module lc_checker
    import lc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             load_wr_i,
    input logic [IDX_W-1:0] load_idx_i,
    input logic             halt_wr_i,
    input logic             halt_i,
    input logic             half_clk_i,
    input logic [CNT_W-1:0] count_o,
    input logic             halt_o,
    input logic             active_o
);
    assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
        (en_i && half_clk_i && !load_wr_i && !halt_o && count_o != '0)
        |=> (count_o == cnt_t'($past(count_o) - cnt_t'(1))));

    assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        (en_i && half_clk_i && !load_wr_i && halt_o) |=> $stable(count_o));

    assert_halt_commit_R4: assert property (@(posedge clk) disable iff (rst)
        halt_wr_i |=> (halt_o == $past(halt_i)));

    assert_reload_apply_R5: assert property (@(posedge clk) disable iff (rst)
        (en_i && load_wr_i && !(half_clk_i && !halt_o && count_o != '0))
        |=> (count_o == lc_len_lookup($past(load_idx_i))));

    assert_reload_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (en_i && load_wr_i && half_clk_i && !halt_o && count_o != '0)
        |=> (count_o == cnt_t'($past(count_o) - cnt_t'(1))));

    assert_disable_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (count_o == '0));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !halt_o));
endmodule

bind lc_length_top lc_checker i_lc_checker (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .load_wr_i (load_wr_i),
    .load_idx_i(load_idx_i),
    .halt_wr_i (halt_wr_i),
    .halt_i    (halt_i),
    .half_clk_i(half_clk_i),
    .count_o   (count_o),
    .halt_o    (halt_o),
    .active_o  (active_o)
);

// File: tb/test_lc_length_top.sv
module test_lc_length_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0, load_wr_i = 1'b0, halt_wr_i = 1'b0;
    logic       halt_i = 1'b0, half_clk_i = 1'b0;
    logic [4:0] load_idx_i = '0;
    logic [7:0] count_o;
    logic       halt_o, active_o;

    always #10 clk = ~clk;

    lc_length_top i_lc_length_top (
        .clk(clk), .rst(rst), .en_i(en_i), .load_wr_i(load_wr_i),
        .load_idx_i(load_idx_i), .halt_wr_i(halt_wr_i), .halt_i(halt_i),
        .half_clk_i(half_clk_i), .count_o(count_o), .halt_o(halt_o),
        .active_o(active_o)
    );

    typedef struct {
        int    cnt;
        bit    hlt;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   vectors = 0;
    int   fails = 0;
    bit   done = 0;
    int   m_count = 0;
    bit   m_halt = 0;

    int tbl[32] = '{10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14,
                    12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30};

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic step(input bit en, input bit lw, input int idx, input bit hw,
                        input bit h, input bit hc, input string tag);
        exp_t e;
        int c;
        bit dec;
        @(negedge clk);
        en_i = en; load_wr_i = lw; load_idx_i = 5'(idx);
        halt_wr_i = hw; halt_i = h; half_clk_i = hc;
        c   = m_count;
        dec = hc && (c != 0) && !m_halt;
        if (dec) c = c - 1;
        if (lw && en && !dec) c = tbl[idx];
        if (!en) c = 0;
        if (hw) m_halt = h;
        m_count = c;
        e.cnt = c; e.hlt = m_halt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each result one time unit after the edge
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            #1;
            e = exp_q.pop_front();
            vectors++;
            if (int'(count_o) != e.cnt || halt_o != e.hlt) begin
                fails++;
                $display("FAIL %s count=%0d halt=%0b expected count=%0d halt=%0b",
                         e.tag, count_o, halt_o, e.cnt, e.hlt);
            end
            if (active_o != (e.cnt != 0)) begin
                fails++;
                $display("FAIL R8 active=%0b expected %0b", active_o, e.cnt != 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (count_o !== 8'd0 || halt_o !== 1'b0 || active_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 count=%0d halt=%0b active=%0b expected 0 0 0",
                     count_o, halt_o, active_o);
        end
        rst = 1'b0;
        // en lw idx hw h hc
        step(1, 1, 0, 0, 0, 0, "R5 reload idx0");
        step(1, 0, 0, 0, 0, 1, "R2 decrement");
        step(1, 0, 0, 1, 1, 1, "R4 set halt on clock");
        step(1, 0, 0, 0, 0, 1, "R3 halted clock");
        step(1, 0, 0, 1, 0, 1, "R4 clear halt on clock");
        step(1, 0, 0, 0, 0, 1, "R2 decrement after clear");
        step(1, 1, 1, 0, 0, 1, "R6 reload dropped");
        step(1, 1, 1, 0, 0, 0, "R5 reload idx1");
        step(1, 0, 0, 1, 1, 0, "R4 halt set");
        step(1, 1, 3, 0, 0, 1, "R6 reload kept while halted");
        step(1, 0, 0, 1, 0, 0, "R4 halt clear");
        step(1, 0, 0, 0, 0, 1, "R2 to one");
        step(1, 0, 0, 0, 0, 1, "R2 to zero");
        step(1, 0, 0, 0, 0, 1, "R2 stays zero");
        step(1, 1, 31, 0, 0, 1, "R6 reload kept at zero");
        step(0, 0, 0, 0, 0, 0, "R7 disable clears");
        step(0, 1, 8, 0, 0, 0, "R7 reload ignored");
        step(1, 0, 0, 0, 0, 0, "R7 enable alone");
        for (int i = 0; i < 32; i++) begin
            step(1, 1, i, 0, 0, 0, "R5 table entry");
            step(1, 0, 0, 0, 0, 1, "R2 table clock");
        end
        step(1, 0, 0, 0, 0, 0, "R3 idle");
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule